// File: doc/BRIEF.md
# Passive JTAG Debug Transaction Monitor

This block listens to a JTAG bus without driving it. It sees TCK, TMS, TDI and TDO, and it follows the 16-state TAP controller in its own tracker. Bits shifted during each instruction or data scan are collected LSB-first. Once a scan completes, a small decoder turns the scan into an event record and presents it on a valid/ready output.

An instruction scan that arrives while the monitor is idle arms the monitor with the decoded opcode. The next data scan is then reported in a form chosen by that opcode, and the monitor returns to idle. A pass-through opcode reports inbound bits only. Identification, abort and unrecognised opcodes report outbound bits only. The two access opcodes report both directions in one record, split into data, address, direction, acknowledge and flag fields.

The TCK pin is the block's clock. Software or a trace buffer downstream consumes the records.

Top module: `dbg_scan_watch`

## Requirements
- R1: While rst_n is low, and after it is released, evt_valid is 0. The TAP tracker starts in Test-Logic-Reset and the monitor starts idle.
- R2: An instruction scan completed while the monitor is idle produces a record with evt_kind=0. evt_instr holds the first 4 bits shifted (the low 4 bits), whatever the scan length, and evt_tdi/evt_len hold the captured bits. The record is valid after the rising edge on which the tracker is in Update-IR.
- R3: A data scan while the monitor is idle produces no record. An instruction scan while an opcode is pending produces no record and leaves the pending opcode unchanged. After reporting a data scan the monitor is idle again.
- R4: With pending opcode 4'b1111, the next data scan gives evt_kind=1 and evt_tdi holds the TDI bits.
- R5: With pending opcode 4'b1110, the next data scan gives evt_kind=2. With 4'b1000 it gives evt_kind=5. Any opcode not named in R4–R6 gives evt_kind=6. In each of these cases evt_tdo holds the TDO bits.
- R6: Opcode 4'b1010 gives evt_kind=3 and opcode 4'b1011 gives evt_kind=4. In both cases evt_data_in=tdi[34:3], evt_addr=tdi[2:1], evt_rnw=tdi[0], evt_data_out=tdo[34:3] and evt_ack=tdo[2:0].
- R7: evt_ack_rsvd is 1 only in an access record (kind 3 or 4) whose evt_ack is neither 3'b001 nor 3'b010.
- R8: evt_warn is 1 only in an abort record (kind 5) in which some bit of tdo[31:1] is nonzero.
- R9: Captured bits are kept LSB-first. Only the first 35 bits of a scan are kept. evt_len counts every shifted bit and saturates at 255.
- R10: Five consecutive rising TCK edges with TMS high put the tracker in Test-Logic-Reset and clear any pending opcode, so a following data scan is not reported.
- R11: While evt_valid=1 and evt_ready=0, the record and evt_valid hold until a new record replaces it. A rising edge with evt_ready=1 and no new record clears evt_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | JTAG test clock, used as the block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tms | input | 1 | Observed test mode select |
| tdi | input | 1 | Observed test data into the target |
| tdo | input | 1 | Observed test data out of the target |
| evt_ready | input | 1 | Consumer accepts the record |
| evt_valid | output | 1 | Record available |
| evt_kind | output | 3 | Event type code (see R2, R4–R6) |
| evt_instr | output | 4 | Decoded opcode the record belongs to |
| evt_tdi | output | 35 | Captured TDI bits, LSB first |
| evt_tdo | output | 35 | Captured TDO bits, LSB first |
| evt_len | output | 8 | Number of bits shifted, saturating |
| evt_data_in | output | 32 | Access write data, tdi[34:3] |
| evt_addr | output | 2 | Access register address, tdi[2:1] |
| evt_rnw | output | 1 | Access direction, tdi[0] |
| evt_data_out | output | 32 | Access read data, tdo[34:3] |
| evt_ack | output | 3 | Access acknowledge, tdo[2:0] |
| evt_ack_rsvd | output | 1 | Acknowledge code is reserved |
| evt_warn | output | 1 | Abort scan has nonzero reserved bits |

## Verification
A record is loaded on the rising edge on which the tracker sits in an Update state. With the TMS walks the bench uses, that is the edge that returns the TAP to Run-Test/Idle, so every record check samples at the falling edge right after that step. Absence of a record is checked at the same falling edge, while evt_ready is held high so that earlier records have already been drained. The hold and clear behaviour is checked at falling edges a few cycles into a stall and one edge after evt_ready rises.

// File: rtl/jtm_pkg.sv
package jtm_pkg;

  localparam int OP_W = 4;

  typedef enum logic [3:0] {
    TAP_RESET, TAP_IDLE,
    TAP_SEL_DR, TAP_CAP_DR, TAP_SHIFT_DR, TAP_EXIT1_DR, TAP_PAUSE_DR, TAP_EXIT2_DR, TAP_UPD_DR,
    TAP_SEL_IR, TAP_CAP_IR, TAP_SHIFT_IR, TAP_EXIT1_IR, TAP_PAUSE_IR, TAP_EXIT2_IR, TAP_UPD_IR
  } tap_e;

  typedef enum logic [2:0] {
    MON_IDLE, MON_PASS, MON_IDENT, MON_DPORT, MON_APORT, MON_ABORT, MON_OTHER
  } mon_e;

  typedef enum logic [2:0] {
    EV_INSTR     = 3'd0,
    EV_PASS_IN   = 3'd1,
    EV_IDENT_OUT = 3'd2,
    EV_DPORT     = 3'd3,
    EV_APORT     = 3'd4,
    EV_ABORT_OUT = 3'd5,
    EV_OTHER_OUT = 3'd6
  } evk_e;

  localparam logic [OP_W-1:0] OP_PASS  = 4'b1111;
  localparam logic [OP_W-1:0] OP_IDENT = 4'b1110;
  localparam logic [OP_W-1:0] OP_DPORT = 4'b1010;
  localparam logic [OP_W-1:0] OP_APORT = 4'b1011;
  localparam logic [OP_W-1:0] OP_ABORT = 4'b1000;

  function automatic mon_e decode_op(input logic [OP_W-1:0] op);
    case (op)
      OP_PASS:  return MON_PASS;
      OP_IDENT: return MON_IDENT;
      OP_DPORT: return MON_DPORT;
      OP_APORT: return MON_APORT;
      OP_ABORT: return MON_ABORT;
      default:  return MON_OTHER;
    endcase
  endfunction

  function automatic evk_e kind_of(input mon_e m);
    case (m)
      MON_PASS:  return EV_PASS_IN;
      MON_IDENT: return EV_IDENT_OUT;
      MON_DPORT: return EV_DPORT;
      MON_APORT: return EV_APORT;
      MON_ABORT: return EV_ABORT_OUT;
      default:   return EV_OTHER_OUT;
    endcase
  endfunction

  function automatic tap_e tap_step(input tap_e s, input logic tms);
    case (s)
      TAP_RESET:    return tms ? TAP_RESET    : TAP_IDLE;
      TAP_IDLE:     return tms ? TAP_SEL_DR   : TAP_IDLE;
      TAP_SEL_DR:   return tms ? TAP_SEL_IR   : TAP_CAP_DR;
      TAP_CAP_DR:   return tms ? TAP_EXIT1_DR : TAP_SHIFT_DR;
      TAP_SHIFT_DR: return tms ? TAP_EXIT1_DR : TAP_SHIFT_DR;
      TAP_EXIT1_DR: return tms ? TAP_UPD_DR   : TAP_PAUSE_DR;
      TAP_PAUSE_DR: return tms ? TAP_EXIT2_DR : TAP_PAUSE_DR;
      TAP_EXIT2_DR: return tms ? TAP_UPD_DR   : TAP_SHIFT_DR;
      TAP_UPD_DR:   return tms ? TAP_SEL_DR   : TAP_IDLE;
      TAP_SEL_IR:   return tms ? TAP_RESET    : TAP_CAP_IR;
      TAP_CAP_IR:   return tms ? TAP_EXIT1_IR : TAP_SHIFT_IR;
      TAP_SHIFT_IR: return tms ? TAP_EXIT1_IR : TAP_SHIFT_IR;
      TAP_EXIT1_IR: return tms ? TAP_UPD_IR   : TAP_PAUSE_IR;
      TAP_PAUSE_IR: return tms ? TAP_EXIT2_IR : TAP_PAUSE_IR;
      TAP_EXIT2_IR: return tms ? TAP_UPD_IR   : TAP_SHIFT_IR;
      default:      return tms ? TAP_SEL_DR   : TAP_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/jtm_tap_tracker.sv
module jtm_tap_tracker
  import jtm_pkg::*;
(
  input  logic tck,
  input  logic rst_n,
  input  logic tms,
  output tap_e tap_q
);

  tap_e tap_d;

  always_comb begin
    tap_d = tap_step(tap_q, tms);
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) tap_q <= TAP_RESET;
    else        tap_q <= tap_d;
  end

endmodule

// File: rtl/jtm_shift_capture.sv
module jtm_shift_capture
  import jtm_pkg::*;
#(
  parameter int KEEP_W = 35,
  parameter int LEN_W  = 8
) (
  input  logic              tck,
  input  logic              rst_n,
  input  tap_e              tap_q,
  input  logic              tdi,
  input  logic              tdo,
  output logic [KEEP_W-1:0] cap_tdi,
  output logic [KEEP_W-1:0] cap_tdo,
  output logic [LEN_W-1:0]  cap_len
);

  localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};

  logic              clr_en, shift_en, upd_en;
  logic [KEEP_W-1:0] tdi_d, tdo_d;
  logic [LEN_W-1:0]  len_d;

  always_comb begin
    clr_en   = (tap_q == TAP_CAP_DR)   || (tap_q == TAP_CAP_IR);
    shift_en = (tap_q == TAP_SHIFT_DR) || (tap_q == TAP_SHIFT_IR);
    upd_en   = clr_en || shift_en;
    tdi_d    = cap_tdi;
    tdo_d    = cap_tdo;
    len_d    = cap_len;
    if (clr_en) begin
      tdi_d = '0;
      tdo_d = '0;
      len_d = '0;
    end else if (shift_en) begin
      for (int i = 0; i < KEEP_W; i++) begin
        if (cap_len == LEN_W'(i)) begin
          tdi_d[i] = tdi;
          tdo_d[i] = tdo;
        end
      end
      if (cap_len != LEN_MAX) len_d = cap_len + 1'b1;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      cap_tdi <= '0;
      cap_tdo <= '0;
      cap_len <= '0;
    end else if (upd_en) begin
      cap_tdi <= tdi_d;
      cap_tdo <= tdo_d;
      cap_len <= len_d;
    end
  end

endmodule

// File: rtl/jtm_event_fsm.sv
module jtm_event_fsm
  import jtm_pkg::*;
#(
  parameter int KEEP_W = 35,
  parameter int LEN_W  = 8
) (
  input  logic              tck,
  input  logic              rst_n,
  input  tap_e              tap_q,
  input  logic [KEEP_W-1:0] cap_tdi,
  input  logic [KEEP_W-1:0] cap_tdo,
  input  logic [LEN_W-1:0]  cap_len,
  input  logic              evt_ready,
  output logic              evt_valid,
  output logic              evt_load,
  output evk_e              evt_kind,
  output logic [OP_W-1:0]   evt_instr,
  output logic [KEEP_W-1:0] evt_tdi,
  output logic [KEEP_W-1:0] evt_tdo,
  output logic [LEN_W-1:0]  evt_len,
  output logic              evt_ack_rsvd,
  output logic              evt_warn
);

  localparam int ACK_W   = 3;
  localparam int RSVD_HI = 31;

  mon_e            mon_q, mon_d;
  logic [OP_W-1:0] op_q, op_d;
  logic            valid_d;
  evk_e            kind_d;
  logic [OP_W-1:0] instr_d;
  logic            rsvd_d, warn_d, access;
  logic [ACK_W-1:0] ack_now;

  always_comb begin
    mon_d    = mon_q;
    op_d     = op_q;
    evt_load = 1'b0;
    kind_d   = EV_INSTR;
    instr_d  = op_q;
    ack_now  = cap_tdo[ACK_W-1:0];
    access   = (mon_q == MON_DPORT) || (mon_q == MON_APORT);
    rsvd_d   = 1'b0;
    warn_d   = 1'b0;
    if (tap_q == TAP_RESET) begin
      mon_d = MON_IDLE;
    end else if ((tap_q == TAP_UPD_IR) && (mon_q == MON_IDLE)) begin
      op_d     = cap_tdi[OP_W-1:0];
      mon_d    = decode_op(cap_tdi[OP_W-1:0]);
      evt_load = 1'b1;
      kind_d   = EV_INSTR;
      instr_d  = cap_tdi[OP_W-1:0];
    end else if ((tap_q == TAP_UPD_DR) && (mon_q != MON_IDLE)) begin
      mon_d    = MON_IDLE;
      evt_load = 1'b1;
      kind_d   = kind_of(mon_q);
      rsvd_d   = access && (ack_now != 3'b001) && (ack_now != 3'b010);
      warn_d   = (mon_q == MON_ABORT) && (|cap_tdo[RSVD_HI:1]);
    end
    if (evt_load)                    valid_d = 1'b1;
    else if (evt_valid && evt_ready) valid_d = 1'b0;
    else                             valid_d = evt_valid;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      mon_q     <= MON_IDLE;
      op_q      <= '0;
      evt_valid <= 1'b0;
    end else begin
      mon_q     <= mon_d;
      op_q      <= op_d;
      evt_valid <= valid_d;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      evt_kind     <= EV_INSTR;
      evt_instr    <= '0;
      evt_tdi      <= '0;
      evt_tdo      <= '0;
      evt_len      <= '0;
      evt_ack_rsvd <= 1'b0;
      evt_warn     <= 1'b0;
    end else if (evt_load) begin
      evt_kind     <= kind_d;
      evt_instr    <= instr_d;
      evt_tdi      <= cap_tdi;
      evt_tdo      <= cap_tdo;
      evt_len      <= cap_len;
      evt_ack_rsvd <= rsvd_d;
      evt_warn     <= warn_d;
    end
  end

endmodule

// File: rtl/dbg_scan_watch.sv
module dbg_scan_watch
  import jtm_pkg::*;
#(
  parameter int KEEP_W = 35,
  parameter int LEN_W  = 8
) (
  input  logic              tck,
  input  logic              rst_n,
  input  logic              tms,
  input  logic              tdi,
  input  logic              tdo,
  input  logic              evt_ready,
  output logic              evt_valid,
  output logic [2:0]        evt_kind,
  output logic [3:0]        evt_instr,
  output logic [KEEP_W-1:0] evt_tdi,
  output logic [KEEP_W-1:0] evt_tdo,
  output logic [LEN_W-1:0]  evt_len,
  output logic [KEEP_W-4:0] evt_data_in,
  output logic [1:0]        evt_addr,
  output logic              evt_rnw,
  output logic [KEEP_W-4:0] evt_data_out,
  output logic [2:0]        evt_ack,
  output logic              evt_ack_rsvd,
  output logic              evt_warn
);

  tap_e              tap_q;
  logic [KEEP_W-1:0] cap_tdi, cap_tdo;
  logic [LEN_W-1:0]  cap_len;
  logic              evt_load;
  evk_e              kind_w;

  jtm_tap_tracker u_tap (
    .tck   (tck),
    .rst_n (rst_n),
    .tms   (tms),
    .tap_q (tap_q)
  );

  jtm_shift_capture #(.KEEP_W(KEEP_W), .LEN_W(LEN_W)) u_cap (
    .tck     (tck),
    .rst_n   (rst_n),
    .tap_q   (tap_q),
    .tdi     (tdi),
    .tdo     (tdo),
    .cap_tdi (cap_tdi),
    .cap_tdo (cap_tdo),
    .cap_len (cap_len)
  );

  jtm_event_fsm #(.KEEP_W(KEEP_W), .LEN_W(LEN_W)) u_fsm (
    .tck          (tck),
    .rst_n        (rst_n),
    .tap_q        (tap_q),
    .cap_tdi      (cap_tdi),
    .cap_tdo      (cap_tdo),
    .cap_len      (cap_len),
    .evt_ready    (evt_ready),
    .evt_valid    (evt_valid),
    .evt_load     (evt_load),
    .evt_kind     (kind_w),
    .evt_instr    (evt_instr),
    .evt_tdi      (evt_tdi),
    .evt_tdo      (evt_tdo),
    .evt_len      (evt_len),
    .evt_ack_rsvd (evt_ack_rsvd),
    .evt_warn     (evt_warn)
  );

  assign evt_kind     = kind_w;
  assign evt_data_in  = evt_tdi[KEEP_W-1:3];
  assign evt_addr     = evt_tdi[2:1];
  assign evt_rnw      = evt_tdi[0];
  assign evt_data_out = evt_tdo[KEEP_W-1:3];
  assign evt_ack      = evt_tdo[2:0];

endmodule

// File: rtl/jtm_checker.sv
module jtm_checker #(
  parameter int KEEP_W = 35,
  parameter int LEN_W  = 8
) (
  input logic              tck,
  input logic              rst_n,
  input logic              tms,
  input logic [3:0]        tap_q,
  input logic              evt_ready,
  input logic              evt_valid,
  input logic              evt_load,
  input logic [2:0]        evt_kind,
  input logic [KEEP_W-1:0] evt_tdi,
  input logic [KEEP_W-1:0] evt_tdo,
  input logic [LEN_W-1:0]  evt_len,
  input logic              evt_ack_rsvd,
  input logic              evt_warn
);

  localparam logic [3:0] S_RESET  = 4'd0;
  localparam logic [3:0] S_UPD_DR = 4'd8;
  localparam logic [3:0] S_UPD_IR = 4'd15;

  logic [2:0] hi_cnt;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)       hi_cnt <= '0;
    else if (!tms)    hi_cnt <= '0;
    else if (hi_cnt != 3'd5) hi_cnt <= hi_cnt + 3'd1;
  end

  assert_five_high_reset_R10: assert property (@(posedge tck) disable iff (!rst_n)
    (hi_cnt == 3'd5) |-> (tap_q == S_RESET));

  assert_record_hold_R11: assert property (@(posedge tck) disable iff (!rst_n)
    (evt_valid && !evt_ready && !evt_load) |=>
      (evt_valid && $stable(evt_tdi) && $stable(evt_tdo) && $stable(evt_kind) && $stable(evt_len)));

  assert_record_drain_R11: assert property (@(posedge tck) disable iff (!rst_n)
    (evt_valid && evt_ready && !evt_load) |=> !evt_valid);

  assert_record_after_update_R2: assert property (@(posedge tck) disable iff (!rst_n)
    $rose(evt_valid) |-> ($past(tap_q) == S_UPD_IR || $past(tap_q) == S_UPD_DR));

  assert_rsvd_only_access_R7: assert property (@(posedge tck) disable iff (!rst_n)
    (evt_valid && evt_ack_rsvd) |-> (evt_kind == 3'd3 || evt_kind == 3'd4));

  assert_warn_only_abort_R8: assert property (@(posedge tck) disable iff (!rst_n)
    (evt_valid && evt_warn) |-> (evt_kind == 3'd5 && evt_tdo[31:1] != '0));

  assert_len_covers_kept_R9: assert property (@(posedge tck) disable iff (!rst_n)
    (evt_valid && evt_len < LEN_W'(KEEP_W)) |-> ((evt_tdi >> evt_len) == '0));

endmodule

bind dbg_scan_watch jtm_checker #(.KEEP_W(KEEP_W), .LEN_W(LEN_W)) u_chk (
  .tck          (tck),
  .rst_n        (rst_n),
  .tms          (tms),
  .tap_q        (tap_q),
  .evt_ready    (evt_ready),
  .evt_valid    (evt_valid),
  .evt_load     (evt_load),
  .evt_kind     (evt_kind),
  .evt_tdi      (evt_tdi),
  .evt_tdo      (evt_tdo),
  .evt_len      (evt_len),
  .evt_ack_rsvd (evt_ack_rsvd),
  .evt_warn     (evt_warn)
);

// File: tb/dbg_scan_watch_test.sv
module dbg_scan_watch_test;

  logic        tck, rst_n, tms, tdi, tdo, evt_ready;
  logic        evt_valid, evt_rnw, evt_ack_rsvd, evt_warn;
  logic [2:0]  evt_kind, evt_ack;
  logic [3:0]  evt_instr;
  logic [34:0] evt_tdi, evt_tdo;
  logic [7:0]  evt_len;
  logic [31:0] evt_data_in, evt_data_out;
  logic [1:0]  evt_addr;

  int total = 0;
  int fails = 0;
  int cyc   = 0;
  bit done  = 0;

  dbg_scan_watch uut (
    .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
    .evt_ready(evt_ready), .evt_valid(evt_valid), .evt_kind(evt_kind),
    .evt_instr(evt_instr), .evt_tdi(evt_tdi), .evt_tdo(evt_tdo),
    .evt_len(evt_len), .evt_data_in(evt_data_in), .evt_addr(evt_addr),
    .evt_rnw(evt_rnw), .evt_data_out(evt_data_out), .evt_ack(evt_ack),
    .evt_ack_rsvd(evt_ack_rsvd), .evt_warn(evt_warn)
  );

  initial tck = 1'b0;
  always #5 tck = ~tck;

  always @(posedge tck) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      total++;
      fails++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 20000", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic di, input logic dout);
    @(negedge tck);
    tms = t; tdi = di; tdo = dout;
  endtask

  task automatic scan_ir(input logic [63:0] v, input int n);
    step(1, 0, 0); step(1, 0, 0); step(0, 0, 0); step(0, 0, 0);
    for (int i = 0; i < n; i++) step(i == n - 1, v[i], 0);
    step(1, 0, 0); step(0, 0, 0);
    @(negedge tck);
  endtask

  task automatic scan_dr(input logic [63:0] vi, input logic [63:0] vo, input int n);
    step(1, 0, 0); step(0, 0, 0); step(0, 0, 0);
    for (int i = 0; i < n; i++) step(i == n - 1, vi[i], vo[i]);
    step(1, 0, 0); step(0, 0, 0);
    @(negedge tck);
  endtask

  task automatic t_reset;
    rst_n = 0; tms = 1; tdi = 0; tdo = 0; evt_ready = 1;
    repeat (3) @(negedge tck);
    check("R1 valid in reset", 64'(evt_valid), 0);
    rst_n = 1;
    step(0, 0, 0);
    @(negedge tck);
    check("R1 valid after reset", 64'(evt_valid), 0);
    scan_dr(64'h5, 64'h0, 3);
    check("R1 idle: no record from DR", 64'(evt_valid), 0);
  endtask

  task automatic t_bypass;
    scan_ir(64'hFF, 8);
    check("R2 ir valid", 64'(evt_valid), 1);
    check("R2 ir kind", 64'(evt_kind), 0);
    check("R2 ir opcode", 64'(evt_instr), 64'hF);
    check("R2 ir len", 64'(evt_len), 8);
    scan_dr(64'h16, 64'h0, 5);
    check("R4 pass valid", 64'(evt_valid), 1);
    check("R4 pass kind", 64'(evt_kind), 1);
    check("R4 pass tdi", 64'(evt_tdi), 64'h16);
    check("R4 pass len", 64'(evt_len), 5);
    scan_dr(64'h3, 64'h0, 2);
    check("R3 back to idle", 64'(evt_valid), 0);
  endtask

  task automatic t_ident;
    scan_ir(64'h2DE, 10);
    check("R2 padded opcode", 64'(evt_instr), 64'hE);
    check("R2 padded tdi", 64'(evt_tdi), 64'h2DE);
    @(negedge tck);
    scan_ir(64'hFF, 8);
    check("R3 ir ignored while pending", 64'(evt_valid), 0);
    scan_dr(64'h0, 64'h3BA00477, 32);
    check("R5 ident kind", 64'(evt_kind), 2);
    check("R3 pending opcode kept", 64'(evt_instr), 64'hE);
    check("R5 ident tdo", 64'(evt_tdo), 64'h3BA00477);
  endtask

  task automatic t_access;
    logic [34:0] wi, wo;
    wi = {32'hCAFE_0123, 2'b10, 1'b1};
    wo = {32'h8765_4321, 3'b010};
    scan_ir(64'hFA, 8);
    scan_dr(64'(wi), 64'(wo), 35);
    check("R6 dp kind", 64'(evt_kind), 3);
    check("R6 data_in", 64'(evt_data_in), 64'hCAFE_0123);
    check("R6 addr", 64'(evt_addr), 2);
    check("R6 rnw", 64'(evt_rnw), 1);
    check("R6 data_out", 64'(evt_data_out), 64'h8765_4321);
    check("R6 ack", 64'(evt_ack), 2);
    check("R7 ok ack not reserved", 64'(evt_ack_rsvd), 0);
    wo = {32'h1, 3'b111};
    scan_ir(64'hFB, 8);
    scan_dr(64'h0, 64'(wo), 35);
    check("R6 ap kind", 64'(evt_kind), 4);
    check("R7 reserved ack", 64'(evt_ack_rsvd), 1);
    scan_ir(64'hFB, 8);
    scan_dr(64'h0, 64'h1, 35);
    check("R7 wait ack", 64'(evt_ack_rsvd), 0);
  endtask

  task automatic t_abort;
    scan_ir(64'hF8, 8);
    scan_dr(64'h0, 64'h20, 35);
    check("R5 abort kind", 64'(evt_kind), 5);
    check("R8 warn set", 64'(evt_warn), 1);
    scan_ir(64'hF8, 8);
    scan_dr(64'h0, 64'h1, 35);
    check("R8 warn clear", 64'(evt_warn), 0);
    scan_ir(64'hF3, 8);
    scan_dr(64'h0, 64'h5A, 8);
    check("R5 other kind", 64'(evt_kind), 6);
    check("R5 other tdo", 64'(evt_tdo), 64'h5A);
    check("R8 no warn outside abort", 64'(evt_warn), 0);
  endtask

  task automatic t_long;
    logic [63:0] v;
    v = 64'hA5_1234_5678;
    scan_ir(64'hFF, 8);
    scan_dr(v, 64'h0, 40);
    check("R9 first 35 kept", 64'(evt_tdi), v & 64'h7_FFFF_FFFF);
    check("R9 full count", 64'(evt_len), 40);
    scan_ir(64'hFF, 8);
    scan_dr(64'h0, 64'h0, 300);
    check("R9 count saturates", 64'(evt_len), 255);
  endtask

  task automatic t_tlr;
    scan_ir(64'hFE, 8);
    repeat (5) step(1, 0, 0);
    step(0, 0, 0);
    @(negedge tck);
    scan_dr(64'h0, 64'h77, 8);
    check("R10 pending cleared", 64'(evt_valid), 0);
    scan_ir(64'hFF, 8);
    check("R10 idle again", 64'(evt_valid), 1);
  endtask

  task automatic t_stall;
    @(negedge tck);
    evt_ready = 0;
    scan_dr(64'h2B, 64'h0, 6);
    repeat (3) @(negedge tck);
    check("R11 held valid", 64'(evt_valid), 1);
    check("R11 held tdi", 64'(evt_tdi), 64'h2B);
    evt_ready = 1;
    @(negedge tck);
    check("R11 drained", 64'(evt_valid), 0);
  endtask

  initial begin
    t_reset;
    t_bypass;
    t_ident;
    t_access;
    t_abort;
    t_long;
    t_tlr;
    t_stall;
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule